// File: doc/BRIEF.md
# Block Load/Store Micro-Op Sequencer

This block receives a single decoded block-memory instruction and expands it into a fixed run of eight doubleword memory requests. The instruction can be a load or a store. It calculates one base effective address, either as the sum of two registers or as a register plus a sign-extended 13-bit immediate. It then issues the eight requests at successive 8-byte steps. Each request is paired with a consecutive register, starting from the instruction's register field.

All legality checks are made once, in the cycle the instruction is accepted:

- the privilege rule, which combines the processor's privileged bit with the address-space identifier;
- the register-field rule;
- the 64-byte alignment rule.

When a check fails, the block reports a two-bit fault code for one cycle and issues no requests. Otherwise each request waits for a valid/ready handshake before the next one is presented.

Store data is read from the selected source register through a combinational register-read port. Load data that comes back on the response port is written to the selected destination register in the cycle it arrives.

Top module: `blk_mem_seq`

## Requirements
- R1: An accepted instruction without a fault produces exactly eight request handshakes with `req_idx` 0 through 7 in order. `req_last` is 1 only on index 7, and no further request follows the eighth.
- R2: In register form (`instr_imm_form`=0) the base is `instr_rs1 + instr_rs2`, and request i carries address base + 8*i.
- R3: In immediate form (`instr_imm_form`=1) the base is `instr_rs1` plus `instr_simm` sign-extended from bit 12, and request i carries address base + 8*i.
- R4: Request i selects register `instr_rd + i` on `src_reg`. The n-th load response is written to register `instr_rd + n`.
- R5: If any of bits 5:0 of the base address is set, the block raises fault code 3 (misaligned).
- R6: If any of bits 3:1 of `instr_rd` is set, the block raises fault code 2 (illegal register). Bit 0 of `instr_rd` has no effect on legality.
- R7: When `priv_mode` is 0 and either bit 7 of `instr_asi` is 0 or `asi_as_if_user` is 1, the block raises fault code 1 (privilege).
- R8: When several faults apply, code 1 wins over code 2, and code 2 wins over code 3.
- R9: A fault sets `fault_valid` for one cycle, in the cycle after acceptance, with the code on `fault_code`. The block issues no request and stays ready for a new instruction.
- R10: A request stays valid with unchanged address and index until `req_ready` is seen high. The index advances only on a completed handshake.
- R11: `instr_ready` is 1 only while idle. An `instr_valid` raised while busy has no effect on the running sequence.
- R12: `req_write` is 1 for stores and 0 for loads. Store requests carry `src_data` on `req_wdata`.
- R13: For a load, `wb_en` is 1 in exactly the cycles where `rsp_valid` is 1, with `wb_data` equal to `rsp_data`.
- R14: After reset, or after reset asserted in the middle of a sequence, the block is idle: `instr_ready`=1, and `req_valid`, `fault_valid` and `wb_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Sequencer idle and able to accept |
| instr_store | input | 1 | 1 = block store, 0 = block load |
| instr_imm_form | input | 1 | 1 = immediate offset, 0 = second register |
| instr_rs1 | input | 64 | First address operand |
| instr_rs2 | input | 64 | Second address operand (register form) |
| instr_simm | input | 13 | Signed immediate (immediate form) |
| instr_rd | input | 5 | First data register number |
| instr_asi | input | 8 | Address space identifier |
| priv_mode | input | 1 | Processor privileged bit |
| asi_as_if_user | input | 1 | Identifier is an as-if-user space |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts request |
| req_write | output | 1 | Request is a write |
| req_addr | output | 64 | Request address |
| req_wdata | output | 64 | Write data |
| req_idx | output | 3 | Micro-op index |
| req_last | output | 1 | Final micro-op of the instruction |
| src_reg | output | 5 | Register read select for store data |
| src_data | input | 64 | Register read data |
| rsp_valid | input | 1 | Load response valid |
| rsp_data | input | 64 | Load response data |
| wb_en | output | 1 | Register write enable |
| wb_reg | output | 5 | Register write select |
| wb_data | output | 64 | Register write data |
| fault_valid | output | 1 | Fault pulse |
| fault_code | output | 2 | 1 privilege, 2 illegal register, 3 misaligned |

## Verification
The fault pulse and the first request both appear one clock after the accepting edge. Each following request appears in the cycle after the previous handshake. A writeback appears combinationally in the same cycle as its response. The block returns to idle one cycle after the last store handshake, or one cycle after the last load response.

The bench drives every input just after the falling edge and samples one time unit later. Each value is therefore compared in the very cycle it is due. The request index is checked against the bench's own handshake count, so a stall that wrongly advances the sequence is caught at the next handshake. The load responder answers one cycle after each handshake, so the eighth writeback falls in the drain cycle that follows the last request.

// File: rtl/blk_mem_seq.sv
module blk_mem_seq #(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int REG_W     = 5,
  parameter int ASI_W     = 8,
  parameter int IMM_W     = 13,
  parameter int NUM_UOPS  = 8,
  parameter int UOP_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic              instr_store,
  input  logic              instr_imm_form,
  input  logic [ADDR_W-1:0] instr_rs1,
  input  logic [ADDR_W-1:0] instr_rs2,
  input  logic [IMM_W-1:0]  instr_simm,
  input  logic [REG_W-1:0]  instr_rd,
  input  logic [ASI_W-1:0]  instr_asi,
  input  logic              priv_mode,
  input  logic              asi_as_if_user,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic [$clog2(NUM_UOPS)-1:0] req_idx,
  output logic              req_last,
  output logic [REG_W-1:0]  src_reg,
  input  logic [DATA_W-1:0] src_data,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              wb_en,
  output logic [REG_W-1:0]  wb_reg,
  output logic [DATA_W-1:0] wb_data,
  output logic              fault_valid,
  output logic [1:0]        fault_code
);
  localparam int IDX_W      = $clog2(NUM_UOPS);
  localparam int STEP_SH    = $clog2(UOP_BYTES);
  localparam int ALIGN_BITS = IDX_W + STEP_SH;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_UOPS - 1);
  localparam logic [1:0] F_NONE = 2'd0, F_PRIV = 2'd1, F_REG = 2'd2, F_ALIGN = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_DRAIN} state_t;

  state_t                       state;
  logic [IDX_W-1:0]             idx, rcnt;
  logic [ADDR_W-ALIGN_BITS-1:0] base_hi;
  logic [REG_W-1:0]             rd_base;
  logic                         is_store;

  logic [ADDR_W-1:0] ea_new;
  logic              priv_fault, reg_fault, align_fault;
  logic [1:0]        fault_sel;
  logic              accept;
  logic              unused_asi;

  assign unused_asi  = ^instr_asi[ASI_W-2:0];
  assign ea_new      = instr_rs1 + (instr_imm_form
                       ? {{(ADDR_W-IMM_W){instr_simm[IMM_W-1]}}, instr_simm}
                       : instr_rs2);
  assign priv_fault  = !priv_mode && (!instr_asi[ASI_W-1] || asi_as_if_user);
  assign reg_fault   = |instr_rd[IDX_W:1];
  assign align_fault = |ea_new[ALIGN_BITS-1:0];
  assign fault_sel   = priv_fault ? F_PRIV : reg_fault ? F_REG : align_fault ? F_ALIGN : F_NONE;

  assign instr_ready = (state == S_IDLE);
  assign accept      = instr_valid && instr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      idx         <= '0;
      rcnt        <= '0;
      base_hi     <= '0;
      rd_base     <= '0;
      is_store    <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= F_NONE;
    end else begin
      fault_valid <= 1'b0;
      fault_code  <= F_NONE;
      if (wb_en) rcnt <= rcnt + 1'b1;
      case (state)
        S_IDLE: if (accept) begin
          if (fault_sel != F_NONE) begin
            fault_valid <= 1'b1;
            fault_code  <= fault_sel;
          end else begin
            state    <= S_ISSUE;
            idx      <= '0;
            rcnt     <= '0;
            base_hi  <= ea_new[ADDR_W-1:ALIGN_BITS];
            rd_base  <= instr_rd;
            is_store <= instr_store;
          end
        end
        S_ISSUE: if (req_ready) begin
          if (idx == LAST_IDX) state <= is_store ? S_IDLE : S_DRAIN;
          else                 idx   <= idx + 1'b1;
        end
        S_DRAIN: if (rsp_valid && rcnt == LAST_IDX) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_valid = (state == S_ISSUE);
  assign req_write = is_store;
  assign req_idx   = idx;
  assign req_last  = (idx == LAST_IDX);
  assign req_addr  = {base_hi, idx, {STEP_SH{1'b0}}};
  assign src_reg   = rd_base + REG_W'(idx);
  assign req_wdata = src_data;

  assign wb_en   = rsp_valid && !is_store && (state != S_IDLE);
  assign wb_reg  = rd_base + REG_W'(rcnt);
  assign wb_data = rsp_data;
endmodule

module blk_mem_seq_chk #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [IDX_W-1:0]  req_idx,
  input logic              req_last,
  input logic              wb_en,
  input logic              fault_valid,
  input logic [1:0]        fault_code
);
  a_r1_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_last |=> req_valid && req_idx == $past(req_idx) + 1'b1);
  a_r1_store_stops: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_last && req_write |=> !req_valid);
  a_r2_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_last |=> req_addr == $past(req_addr) + ADDR_W'(8));
  a_r5_block_offset: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[IDX_W+2:0] == {req_idx, 3'b000});
  a_r9_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !req_valid && instr_ready && fault_code != 2'd0);
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_idx));
  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !instr_ready);
  a_r13_wb_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !instr_ready && !req_write);
endmodule

bind blk_mem_seq blk_mem_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk (.*);

// File: tb/blk_mem_seq_test.sv
module blk_mem_seq_test;
  localparam logic [63:0] RSP_KEY = 64'h5A5A_3C3C_A5A5_C3C3;

  typedef struct packed {
    logic        st;
    logic        imm;
    logic [63:0] rs1;
    logic [63:0] rs2;
    logic [12:0] simm;
    logic [4:0]  rd;
    logic [7:0]  asi;
    logic        priv;
    logic        auser;
    logic [1:0]  code;
    logic        stall;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 64'h1000, 64'h40, 13'h0, 5'd0, 8'h80, 1'b0, 1'b0, 2'd0, 1'b0},
    '{1'b1, 1'b1, 64'h2000, 64'h0, 13'h1FC0, 5'd16, 8'h14, 1'b1, 1'b0, 2'd0, 1'b1},
    '{1'b0, 1'b1, 64'h3000, 64'h0, 13'h00C0, 5'd17, 8'h80, 1'b1, 1'b0, 2'd0, 1'b1},
    '{1'b1, 1'b0, 64'h1001, 64'h0, 13'h0, 5'd0, 8'h80, 1'b1, 1'b0, 2'd3, 1'b0},
    '{1'b0, 1'b0, 64'h1000, 64'h0, 13'h0, 5'd2, 8'h80, 1'b1, 1'b0, 2'd2, 1'b0},
    '{1'b0, 1'b0, 64'h1000, 64'h0, 13'h0, 5'd0, 8'h10, 1'b0, 1'b0, 2'd1, 1'b0},
    '{1'b1, 1'b0, 64'h1000, 64'h0, 13'h0, 5'd0, 8'h80, 1'b0, 1'b1, 2'd1, 1'b0},
    '{1'b0, 1'b0, 64'h1004, 64'h0, 13'h0, 5'd4, 8'h00, 1'b0, 1'b0, 2'd1, 1'b0},
    '{1'b1, 1'b1, 64'h1000, 64'h0, 13'h0008, 5'd8, 8'h80, 1'b1, 1'b0, 2'd2, 1'b0},
    '{1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFC0, 64'h80, 13'h0, 5'd1, 8'h80, 1'b0, 1'b0, 2'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0, instr_store = 1'b0, instr_imm_form = 1'b0;
  logic [63:0] instr_rs1 = '0, instr_rs2 = '0;
  logic [12:0] instr_simm = '0;
  logic [4:0]  instr_rd = '0;
  logic [7:0]  instr_asi = '0;
  logic        priv_mode = 1'b0, asi_as_if_user = 1'b0;
  logic        req_ready = 1'b0, rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;
  logic        instr_ready, req_valid, req_write, req_last, wb_en, fault_valid;
  logic [63:0] req_addr, req_wdata, wb_data, src_data;
  logic [2:0]  req_idx;
  logic [4:0]  src_reg, wb_reg;
  logic [1:0]  fault_code;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;
  assign src_data = {32'hDEAD_BEEF, 27'd0, src_reg};

  blk_mem_seq uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [63:0] base, pend_addr;
    int cnt, rc, cyc;
    bit pend;
    base = v.rs1 + (v.imm ? {{51{v.simm[12]}}, v.simm} : v.rs2);
    @(negedge clk);
    instr_valid = 1'b1; instr_store = v.st; instr_imm_form = v.imm;
    instr_rs1 = v.rs1; instr_rs2 = v.rs2; instr_simm = v.simm; instr_rd = v.rd;
    instr_asi = v.asi; priv_mode = v.priv; asi_as_if_user = v.auser;
    @(negedge clk);
    instr_valid = 1'b0;
    if (v.code != 2'd0) begin
      #1;
      chk(fault_valid == 1'b1, "R9 fault pulse", 64'(fault_valid), 64'd1);
      chk(fault_code == v.code, "R5/R6/R7/R8 fault code", 64'(fault_code), 64'(v.code));
      chk(req_valid == 1'b0, "R9 no request on fault", 64'(req_valid), 64'd0);
      @(negedge clk); #1;
      chk(fault_valid == 1'b0 && req_valid == 1'b0 && instr_ready == 1'b1,
          "R9 pulse ends idle", {fault_valid, req_valid, instr_ready}, 64'b001);
      return;
    end
    cnt = 0; rc = 0; cyc = 0; pend = 0; pend_addr = '0;
    while (!(cnt == 8 && (v.st || rc == 8)) && cyc < 200) begin
      if (cyc > 0) @(negedge clk);
      rsp_valid = pend; rsp_data = pend_addr ^ RSP_KEY; pend = 0;
      req_ready = v.stall ? (cyc % 3 != 1) : 1'b1;
      instr_valid = v.stall && cnt < 8;
      instr_rs1 = ~v.rs1;
      #1;
      chk(instr_ready == 1'b0, "R11 busy", 64'(instr_ready), 64'd0);
      if (rsp_valid) begin
        chk(wb_en == 1'b1, "R13 wb_en", 64'(wb_en), 64'd1);
        chk(wb_reg == v.rd + 5'(rc), "R4 wb_reg", 64'(wb_reg), 64'(v.rd + 5'(rc)));
        chk(wb_data == ((base + 64'(8*rc)) ^ RSP_KEY), "R13 wb_data", wb_data,
            (base + 64'(8*rc)) ^ RSP_KEY);
        rc++;
      end else begin
        chk(wb_en == 1'b0, "R13 no wb", 64'(wb_en), 64'd0);
      end
      if (cnt < 8) chk(req_valid == 1'b1, "R10 request held", 64'(req_valid), 64'd1);
      else         chk(req_valid == 1'b0, "R1 no ninth request", 64'(req_valid), 64'd0);
      if (req_valid && req_ready) begin
        chk(req_addr == base + 64'(8*cnt), v.imm ? "R3 address" : "R2 address",
            req_addr, base + 64'(8*cnt));
        chk(req_idx == 3'(cnt), "R1 index", 64'(req_idx), 64'(cnt));
        chk(req_last == (cnt == 7), "R1 last flag", 64'(req_last), 64'(cnt == 7));
        chk(req_write == v.st, "R12 write flag", 64'(req_write), 64'(v.st));
        if (v.st) begin
          chk(src_reg == v.rd + 5'(cnt), "R4 src_reg", 64'(src_reg), 64'(v.rd + 5'(cnt)));
          chk(req_wdata == {32'hDEAD_BEEF, 27'd0, v.rd + 5'(cnt)}, "R12 wdata", req_wdata,
              {32'hDEAD_BEEF, 27'd0, v.rd + 5'(cnt)});
        end else begin
          pend = 1; pend_addr = req_addr;
        end
        cnt++;
      end
      cyc++;
    end
    @(negedge clk);
    instr_valid = 1'b0; rsp_valid = 1'b0; req_ready = 1'b0;
    #1;
    chk(cnt == 8, "R1 eight requests", 64'(cnt), 64'd8);
    chk(instr_ready == 1'b1 && req_valid == 1'b0, "R1 idle after sequence",
        {instr_ready, req_valid}, 64'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(instr_ready == 1'b1 && req_valid == 1'b0 && fault_valid == 1'b0 && wb_en == 1'b0,
        "R14 reset state", {instr_ready, req_valid, fault_valid, wb_en}, 64'b1000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R14: reset in the middle of a store sequence
    @(negedge clk);
    instr_valid = 1'b1; instr_store = 1'b1; instr_imm_form = 1'b0;
    instr_rs1 = 64'h4000; instr_rs2 = 64'h0; instr_rd = 5'd0;
    instr_asi = 8'h80; priv_mode = 1'b1; asi_as_if_user = 1'b0;
    @(negedge clk);
    instr_valid = 1'b0; req_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0; req_ready = 1'b0;
    @(negedge clk); #1;
    chk(instr_ready == 1'b1 && req_valid == 1'b0, "R14 mid-sequence reset",
        {instr_ready, req_valid}, 64'b10);
    rst_n = 1'b1;
    run_vec(VEC[0]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule